// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block sequences one block-transfer instruction that moves a group of registers to or from memory in a core with 32 general registers. On a start pulse it decodes the instruction word, latches a 16-bit register selection mask, the bank bit and the base register value, and then walks through the selected registers one per cycle. For each register it presents a word address and a 5-bit register index on a simple request interface, and it holds the current request while memory is not ready.

Each instruction reaches only one half of the register file. The bank bit selects registers 0 to 15 or 16 to 31, and the mask is split into two fields around that bit in the encoding. When the last transfer is accepted, the block pulses `done` and, if writeback was requested, gives the updated base value and the base register index so the pipeline can write them.

Top module: `lsm_seq`

## Requirements
- R1: A start is accepted only when `busy` is low, instr[31:29] is 3'b100 and instr[8:7] is 2'b00. Any other start is ignored: `busy` stays low and no `done` follows.
- R2: The fields are taken as follows. Pre-index is bit 28, up is bit 27, the passthrough flag is bit 26, writeback is bit 25, load is bit 24 and the base register is bits 23:19. The bank bit is bit 6. The mask is {instr[18:9], instr[5:0]}, so mask bit i sits at instr[i] for i below 6 and at instr[i+3] for i of 6 and above.
- R3: The bank bit H selects the register half. Mask bit i requests register index {H, i[3:0]}, so it is register i when H is 0 and register 16+i when H is 1.
- R4: Selected registers are issued in ascending index order. Each request accepted with `mem_rdy` high moves to the next selected register in the following cycle.
- R5: Let n be the number of set mask bits. The first address is base+4·P for an up transfer (bit 27 = 1) and base−4n+4·(1−P) for a down transfer.
- R6: Each accepted request adds 4 to the address. Every issued address has bits 1:0 equal to 0.
- R7: While `req_valid` is high and `mem_rdy` is low, the address, register index and direction are held in the next cycle.
- R8: `busy` and `req_valid` are high from the cycle after an accepted non-empty start until the last request is accepted. `done` is a one-cycle pulse in the cycle that follows that acceptance, with `busy` low.
- R9: A start with an empty mask makes no request and pulses `done` in the cycle after the start.
- R10: `wb_valid` is high together with `done` exactly when the writeback bit was set. `wb_value` is then base+4n for up and base−4n for down, and `wb_reg` is the base register field.
- R11: `req_load` gives the load bit and `req_alt` gives the passthrough flag of the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a new instruction |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Current value of the base register |
| mem_rdy | input | 1 | Memory accepts the current request |
| busy | output | 1 | Sequence in progress; pipeline must stall |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Request valid |
| req_load | output | 1 | 1 = load, 0 = store |
| req_alt | output | 1 | Passthrough flag from the instruction |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 5 | Register index of the request |
| wb_valid | output | 1 | Base writeback valid, with done |
| wb_reg | output | 5 | Base register index |
| wb_value | output | 32 | Updated base value |

## Verification
A corrupted selection mask or bank bit shows at the ports on the very next request as a wrong or skipped register index. It also shows as a transfer count that is off, which moves the `done` pulse by one or more cycles. An address register that steps wrongly or takes the wrong starting offset is visible on the first or second issued address. Random stall patterns on `mem_rdy` show whether a held request drifts. A wrong count changes the down-transfer start address and the writeback value in the same instruction.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   localparam int LSM_MASK_W = 16;
   localparam int LSM_RN_W   = 5;

   typedef struct packed {
      logic                  pre;
      logic                  up;
      logic                  alt;
      logic                  wback;
      logic                  load;
      logic [LSM_RN_W-1:0]   rn;
      logic                  bank;
      logic [LSM_MASK_W-1:0] mask;
   } lsm_fields_t;
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
   import lsm_pkg::*;
#(
   parameter int MASK_W = LSM_MASK_W
) (
   input  logic [31:0]  instr,
   output lsm_fields_t  fields,
   output logic         is_lsm
);
   generate
      if (MASK_W != 16) begin : g_bad_w
         $error("lsm_decode: encoding carries exactly 16 mask bits");
      end
   endgenerate

   // R1: class code and the two zero pad bits
   assign is_lsm = (instr[31:29] == 3'b100) && (instr[8:7] == 2'b00);

   // R2: field positions
   always_comb begin
      fields.pre   = instr[28];
      fields.up    = instr[27];
      fields.alt   = instr[26];
      fields.wback = instr[25];
      fields.load  = instr[24];
      fields.rn    = instr[23:19];
      fields.bank  = instr[6];
      fields.mask  = {instr[18:9], instr[5:0]};
   end
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
   parameter int MASK_W = 16,
   localparam int CNT_W = $clog2(MASK_W + 1)
) (
   input  logic [MASK_W-1:0] mask,
   output logic [CNT_W-1:0]  cnt
);
   logic [CNT_W-1:0] part [MASK_W+1];

   assign part[0] = '0;
   for (genvar g = 0; g < MASK_W; g++) begin : g_sum
      assign part[g+1] = part[g] + CNT_W'(mask[g]);
   end
   assign cnt = part[MASK_W];
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
   parameter int MASK_W     = 16,
   parameter bit ENC_ONEHOT = 1'b1,
   localparam int IDX_W     = $clog2(MASK_W)
) (
   input  logic [MASK_W-1:0] mask,
   output logic [MASK_W-1:0] onehot,
   output logic [IDX_W-1:0]  idx
);
   assign onehot = mask & (~mask + 1'b1);

   generate
      if (ENC_ONEHOT) begin : g_enc
         always_comb begin
            idx = '0;
            for (int i = 0; i < MASK_W; i++)
               if (onehot[i]) idx = idx | IDX_W'(i);
         end
      end else begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = MASK_W - 1; i >= 0; i--)
               if (mask[i]) idx = IDX_W'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
   import lsm_pkg::*;
#(
   parameter int AW         = 32,
   parameter int MASK_W     = LSM_MASK_W,
   parameter int WORD_BYTES = 4,
   parameter bit ENC_ONEHOT = 1'b1,
   localparam int CNT_W     = $clog2(MASK_W + 1),
   localparam int IDX_W     = $clog2(MASK_W),
   localparam int REG_W     = IDX_W + 1,
   localparam int SH        = $clog2(WORD_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [31:0]      instr,
   input  logic [AW-1:0]    base_val,
   input  logic             mem_rdy,
   output logic             busy,
   output logic             done,
   output logic             req_valid,
   output logic             req_load,
   output logic             req_alt,
   output logic [AW-1:0]    req_addr,
   output logic [REG_W-1:0] req_reg,
   output logic             wb_valid,
   output logic [LSM_RN_W-1:0] wb_reg,
   output logic [AW-1:0]    wb_value
);
   generate
      if (AW < 8 || WORD_BYTES != 4 || REG_W != LSM_RN_W) begin : g_bad_cfg
         $error("lsm_seq: unsupported parameter combination");
      end
   endgenerate

   lsm_fields_t f;
   logic        dec_ok;
   logic [CNT_W-1:0]  cnt;
   logic [MASK_W-1:0] low_oh;
   logic [IDX_W-1:0]  low_idx;

   logic              busy_q, done_q, bank_q, load_q, alt_q, wb_q;
   logic [MASK_W-1:0] mask_q;
   logic [AW-1:0]     addr_q, wbval_q;
   logic [LSM_RN_W-1:0] rn_q;

   lsm_decode #(.MASK_W(MASK_W)) u_dec (.instr(instr), .fields(f), .is_lsm(dec_ok));
   lsm_popcnt #(.MASK_W(MASK_W)) u_pop (.mask(f.mask), .cnt(cnt));
   lsm_lowbit #(.MASK_W(MASK_W), .ENC_ONEHOT(ENC_ONEHOT)) u_low (
      .mask(mask_q), .onehot(low_oh), .idx(low_idx));

   // R5, R10: span, start address, final base
   logic [AW-1:0] step, span, start_raw, wb_calc;
   logic          accept, last, beat;

   assign step      = AW'(WORD_BYTES);
   assign span      = AW'(cnt) << SH;
   assign start_raw = f.up ? (base_val + (f.pre ? step : '0))
                           : (base_val - span + (f.pre ? '0 : step));
   assign wb_calc   = f.up ? (base_val + span) : (base_val - span);
   assign accept    = start && dec_ok && !busy_q;
   assign beat      = busy_q && mem_rdy;
   assign last      = (mask_q & (mask_q - 1'b1)) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         bank_q  <= 1'b0;
         load_q  <= 1'b0;
         alt_q   <= 1'b0;
         wb_q    <= 1'b0;
         mask_q  <= '0;
         addr_q  <= '0;
         wbval_q <= '0;
         rn_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            bank_q  <= f.bank;
            load_q  <= f.load;
            alt_q   <= f.alt;
            wb_q    <= f.wback;
            rn_q    <= f.rn;
            wbval_q <= wb_calc;
            mask_q  <= f.mask;
            addr_q  <= {start_raw[AW-1:SH], {SH{1'b0}}};
            if (f.mask == '0) done_q <= 1'b1;   // R9
            else              busy_q <= 1'b1;
         end else if (beat) begin
            mask_q <= mask_q & ~low_oh;          // R4
            addr_q <= addr_q + step;             // R6
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;                   // R8
            end
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign req_valid = busy_q;
   assign req_load  = load_q;
   assign req_alt   = alt_q;
   assign req_addr  = addr_q;
   assign req_reg   = {bank_q, low_idx};        // R3
   assign wb_valid  = done_q && wb_q;            // R10
   assign wb_reg    = rn_q;
   assign wb_value  = wbval_q;

   p_ignore_bad_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !dec_ok) |=> (!busy && !done));
   p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mem_rdy) |=> (!req_valid || (req_reg > $past(req_reg))));
   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mem_rdy) |=> (!req_valid || (req_addr == $past(req_addr) + step)));
   p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[1:0] == 2'b00));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mem_rdy) |=> (req_valid && $stable(req_addr) && $stable(req_reg)
                                   && $stable(req_load)));
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) || $past(start)));
   p_wb_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done);
endmodule

// File: tb/lsm_seq_tb_top.sv
module lsm_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] base_val = '0;
   logic        mem_rdy = 1'b0;
   logic        busy, done, req_valid, req_load, req_alt, wb_valid;
   logic [31:0] req_addr, wb_value;
   logic [4:0]  req_reg, wb_reg;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   lsm_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base_val(base_val),
      .mem_rdy(mem_rdy), .busy(busy), .done(done), .req_valid(req_valid),
      .req_load(req_load), .req_alt(req_alt), .req_addr(req_addr), .req_reg(req_reg),
      .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit p, input bit u, input bit s, input bit w,
                                      input bit l, input logic [4:0] rn, input bit h,
                                      input logic [15:0] m);
      return {3'b100, p, u, s, w, l, rn, m[15:6], 2'b00, h, m[5:0]};
   endfunction

   function automatic int popc(input logic [15:0] m);
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(m[i]);
      return c;
   endfunction

   task automatic run_op(input logic [31:0] ins, input logic [31:0] base, input bit poke,
                         input int rdy_pct);
      logic [15:0] m;
      logic [4:0]  regs [16];
      logic [31:0] a0, wbe, four_n;
      int n, k, guard;
      bit rdy;
      m = {ins[18:9], ins[5:0]};
      n = popc(m);
      k = 0;
      for (int i = 0; i < 16; i++)
         if (m[i]) begin regs[k] = {ins[6], i[3:0]}; k++; end
      four_n = 32'(n) * 4;
      a0  = ins[27] ? base + (ins[28] ? 32'd4 : 32'd0)
                    : base - four_n + (ins[28] ? 32'd0 : 32'd4);
      a0  = a0 & ~32'd3;
      wbe = ins[27] ? base + four_n : base - four_n;

      instr = ins; base_val = base; start = 1'b1; mem_rdy = 1'b0;
      @(negedge clk);
      start = 1'b0;
      if (n == 0) begin
         chk(done == 1'b1, "R9 done after empty start", 32'(done), 1);
         chk(req_valid == 1'b0 && busy == 1'b0, "R9 no request", 32'(req_valid), 0);
      end else begin
         k = 0; guard = 0;
         while (k < n && guard < 2000) begin
            start = 1'b0;
            chk(busy == 1'b1 && req_valid == 1'b1, "R8 busy during sequence", 32'(busy), 1);
            chk(req_addr == a0 + 32'(k) * 4, k == 0 ? "R5 first address" : "R6 address step",
                req_addr, a0 + 32'(k) * 4);
            chk(req_reg == regs[k], "R3 R4 register order", 32'(req_reg), 32'(regs[k]));
            chk(req_load == ins[24] && req_alt == ins[26], "R11 direction flags",
                {30'd0, req_load, req_alt}, {30'd0, ins[24], ins[26]});
            rdy = ($urandom % 100) < rdy_pct;
            if (poke && guard == 0) begin
               rdy = 1'b0;
               start = 1'b1;
               instr = mk(1, 1, 0, 1, 1, 5'd3, ~ins[6], 16'h8001);
            end
            mem_rdy = rdy;
            @(negedge clk);
            if (rdy) k++;
            guard++;
         end
         mem_rdy = 1'b0; start = 1'b0;
         chk(done == 1'b1 && busy == 1'b0 && req_valid == 1'b0, "R8 done pulse",
             {29'd0, done, busy, req_valid}, 32'd4);
      end
      chk(wb_valid == ins[25], "R10 writeback valid", 32'(wb_valid), 32'(ins[25]));
      if (ins[25]) begin
         chk(wb_value == wbe, "R10 writeback value", wb_value, wbe);
         chk(wb_reg == ins[23:19], "R10 writeback register", 32'(wb_reg), 32'(ins[23:19]));
      end
      @(negedge clk);
      chk(done == 1'b0, "R8 done lasts one cycle", 32'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = int'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && req_valid == 0 && wb_valid == 0, "R8 reset state",
          {28'd0, busy, done, req_valid, wb_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: wrong class and nonzero pad bits are ignored
      instr = {3'b101, 29'h0FF_FFFF & 29'h1FFF_FE7F}; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 0 && done == 0, "R1 wrong class ignored", {30'd0, busy, done}, 0);
      @(negedge clk);
      chk(done == 0, "R1 no done for wrong class", 32'(done), 0);
      instr = mk(1, 1, 0, 1, 0, 5'd2, 0, 16'h00FF) | 32'h0000_0180; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 0 && done == 0, "R1 nonzero pad ignored", {30'd0, busy, done}, 0);
      @(negedge clk);

      // directed corners (R2 field split, R9 empty, full masks, both banks)
      run_op(mk(0, 1, 0, 1, 1, 5'd13, 0, 16'h0000), 32'h0000_1000, 0, 100);
      run_op(mk(1, 0, 1, 1, 0, 5'd31, 1, 16'hFFFF), 32'h0000_2000, 0, 100);
      run_op(mk(0, 0, 0, 1, 1, 5'd1, 0, 16'hFFFF), 32'h0000_2000, 0, 50);
      run_op(mk(1, 1, 0, 0, 0, 5'd7, 1, 16'h8001), 32'h0000_0102, 0, 100);
      run_op(mk(0, 1, 1, 1, 1, 5'd9, 1, 16'h0040), 32'h0000_3000, 1, 30);   // R2 mask bit 6
      run_op(mk(1, 0, 0, 1, 0, 5'd0, 0, 16'h0020), 32'h0000_0010, 0, 100);  // R2 mask bit 5

      for (int t = 0; t < 60; t++) begin
         logic [15:0] m;
         m = 16'($urandom);
         if (t % 5 == 0) m = m & 16'($urandom);
         run_op(mk(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   5'($urandom), 1'($urandom), m),
                ($urandom & 32'h00FF_FFFC) | 32'h0010_0000, (t % 7) == 3, 25 + (t % 4) * 25);
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule